// File: doc/BRIEF.md
# Iterative HI/LO Multiplier

This unit forms the 64-bit product of two 32-bit operands. The operands are read either as two's-complement values or as unsigned values. The product is split across two persistent registers: HI holds the upper word and LO holds the lower word. A processor pipeline uses the unit in two ways. It issues a multiply, and later it issues a read command that places HI or LO on the result bus for register-file writeback.

The multiply is iterative. At launch the unit takes the operand magnitudes and runs one shift-add step per cycle for 32 cycles. For a signed multiply it negates the sum on the last step when exactly one operand was negative. While a multiply is running, the unit holds `busy` high. A request offered during that time is not taken; the requester keeps it on the inputs until `busy` drops. As a result, a register read issued behind a multiply stalls and then returns the new value.

Top module: `hilo_mul`

## Requirements
- R1: With `cmd` = 2'b00 (signed multiply), both operands are treated as two's-complement. After completion HI holds bits 63:32 and LO holds bits 31:0 of their 64-bit signed product.
- R2: With `cmd` = 2'b01 (unsigned multiply), both operands are treated as unsigned. HI and LO receive the upper and lower words of the 64-bit unsigned product.
- R3: With `cmd` = 2'b10 the current HI value is returned, and with `cmd` = 2'b11 the current LO value is returned. In both cases `result` carries the value and `done` is high in the cycle after acceptance.
- R4: A read command leaves HI and LO unchanged.
- R5: HI and LO keep their values across any number of reads and idle cycles until the next multiply completes.
- R6: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. After a multiply is accepted, `busy` is high for exactly 32 cycles. `done` is high in the cycle in which `busy` has just fallen, and not while `busy` is high.
- R7: A request offered while `busy` is high is not accepted. If it is held, it is accepted on the first edge after `busy` falls, so a read held behind a multiply returns that multiply's result.
- R8: After reset, HI and LO are zero and `busy`, `done` and `result` are low.
- R9: `result` is zero in every cycle except the one that completes a read, including the completion cycle of a multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, held until accepted |
| cmd | input | 2 | 00 signed mult, 01 unsigned mult, 10 read HI, 11 read LO |
| op_a | input | 32 | First multiply operand |
| op_b | input | 32 | Second multiply operand |
| busy | output | 1 | Multiply in progress; new requests wait |
| done | output | 1 | One-cycle completion flag for a multiply or a read |
| result | output | 32 | Read data for a completing read, otherwise zero |

## Verification
Random operand pairs are run through both signed and unsigned multiplies, each followed by reads of both halves.

A run of random pairs under the wrong signedness would show a mixed-up sign correction. Operands with the top bit set separate the signed and unsigned paths. The most negative value times itself exercises the magnitude that cannot be represented as a positive 32-bit number. Minus one times one and zero times anything check the negation on a single negative operand and a zero product.

Reads are repeated and interleaved with idle time to show that HI and LO persist. A read held during a running multiply shows that the stall returns the fresh product rather than the previous one.

// File: rtl/hilo_mul.sv
module hilo_mul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [1:0]   cmd,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int CW = $clog2(W);
  localparam int PW = 2 * W;

  logic [W-1:0]  hi_q, lo_q, mplier_q, res_q;
  logic [PW-1:0] mcand_q, acc_q;
  logic [CW-1:0] step_q;
  logic          busy_q, done_q, neg_q;

  wire take    = req_valid & ~busy_q;
  wire sgn     = (cmd == 2'b00);
  wire a_neg   = sgn & op_a[W-1];
  wire b_neg   = sgn & op_b[W-1];
  wire [W-1:0] a_mag = a_neg ? -op_a : op_a;
  wire [W-1:0] b_mag = b_neg ? -op_b : op_b;
  wire [PW-1:0] acc_nx = acc_q + (mplier_q[0] ? mcand_q : '0);
  wire [PW-1:0] prod   = neg_q ? -acc_nx : acc_nx;
  wire last = (step_q == CW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= '0;
      lo_q     <= '0;
      mplier_q <= '0;
      mcand_q  <= '0;
      acc_q    <= '0;
      step_q   <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      neg_q    <= 1'b0;
      res_q    <= '0;
    end else begin
      done_q <= 1'b0;
      res_q  <= '0;
      if (take) begin
        if (cmd[1]) begin
          done_q <= 1'b1;
          res_q  <= cmd[0] ? lo_q : hi_q;
        end else begin
          busy_q   <= 1'b1;
          step_q   <= '0;
          acc_q    <= '0;
          mcand_q  <= {{W{1'b0}}, a_mag};
          mplier_q <= b_mag;
          neg_q    <= a_neg ^ b_neg;
        end
      end else if (busy_q) begin
        acc_q    <= acc_nx;
        mcand_q  <= mcand_q << 1;
        mplier_q <= mplier_q >> 1;
        step_q   <= step_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          hi_q   <= prod[PW-1:W];
          lo_q   <= prod[W-1:0];
        end
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = res_q;
endmodule

// File: rtl/hilo_mul_chk.sv
module hilo_mul_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic [1:0]   cmd,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  wire take = req_valid && !busy;

  p_read_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd == 2'b10) |=> (done && result == $past(hi)));
  p_read_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd == 2'b11) |=> (done && result == $past(lo)));
  p_read_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd[1]) |=> ($stable(hi) && $stable(lo)));
  p_idle_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(hi) && $stable(lo)));
  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cmd[1]) |=> busy);
  p_busy_no_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
  p_fall_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_result_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (result == '0));
endmodule

bind hilo_mul hilo_mul_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cmd(cmd),
  .busy(busy), .done(done), .result(result), .hi(hi_q), .lo(lo_q)
);

// File: tb/hilo_mul_bench.sv
module hilo_mul_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  cmd = 2'b00;
  logic [31:0] op_a = '0, op_b = '0;
  logic        busy, done;
  logic [31:0] result;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  hilo_mul u_hilo_mul (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cmd(cmd),
    .op_a(op_a), .op_b(op_b), .busy(busy), .done(done), .result(result)
  );

  function automatic logic [63:0] ref_prod(logic sgn, logic [31:0] a, logic [31:0] b);
    logic [63:0] xa = sgn ? {{32{a[31]}}, a} : {32'b0, a};
    logic [63:0] xb = sgn ? {{32{b[31]}}, b} : {32'b0, b};
    return xa * xb;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] c, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    req_valid = 1'b1; cmd = c; op_a = a; op_b = b;
    while (busy) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic read(logic [1:0] c, output logic [31:0] v);
    issue(c, '0, '0);
    check("R3 done", done, 1);
    v = result;
  endtask

  task automatic do_mul(logic sgn, logic [31:0] a, logic [31:0] b);
    int n = 0;
    logic [31:0] h, l;
    logic [63:0] p = ref_prod(sgn, a, b);
    issue(sgn ? 2'b00 : 2'b01, a, b);
    while (busy) begin
      n++;
      if (done) check("R6 done during busy", done, 0);
      @(negedge clk);
    end
    check("R6 latency", n, 32);
    check("R6 done", done, 1);
    check("R9 result zero", result, 0);
    read(2'b10, h);
    read(2'b11, l);
    check(sgn ? "R1/R3 hi" : "R2/R3 hi", h, p[63:32]);
    check(sgn ? "R1/R3 lo" : "R2/R3 lo", l, p[31:0]);
    read(2'b10, h);
    check("R4 hi after read", h, p[63:32]);
  endtask

  initial begin
    logic [31:0] v;
    logic [63:0] p;
    void'($urandom(32'd20240));
    #1;
    check("R8 busy", busy, 0);
    check("R8 done", done, 0);
    check("R8 result", result, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    read(2'b10, v); check("R8 hi", v, 0);
    read(2'b11, v); check("R8 lo", v, 0);

    do_mul(1, 32'h8000_0000, 32'h8000_0000);
    do_mul(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    do_mul(1, 32'hFFFF_FFFF, 32'd1);
    do_mul(1, 32'd7, 32'hFFFF_FFFD);
    do_mul(0, 32'h8000_0000, 32'd2);
    do_mul(1, 32'd0, 32'hDEAD_BEEF);
    do_mul(0, 32'hFFFF_FFFF, 32'h0);

    p = ref_prod(1, 32'h1234_5678, 32'h9ABC_DEF0);
    do_mul(1, 32'h1234_5678, 32'h9ABC_DEF0);
    repeat (20) @(negedge clk);
    read(2'b11, v); read(2'b11, v);
    check("R5 lo kept", v, p[31:0]);
    read(2'b10, v);
    check("R5 hi kept", v, p[63:32]);

    for (int i = 0; i < 40; i++)
      do_mul($urandom_range(1, 0), $urandom, $urandom);

    begin
      logic [31:0] a = 32'hCAFE_0001, b = 32'h8765_4321;
      int waited = 0;
      p = ref_prod(0, a, b);
      issue(2'b01, a, b);
      req_valid = 1'b1; cmd = 2'b10;
      while (busy) begin
        waited++;
        @(negedge clk);
      end
      check("R7 stalled while busy", waited > 0, 1);
      @(negedge clk);
      req_valid = 1'b0;
      check("R7 read done", done, 1);
      check("R7 read new hi", result, p[63:32]);
      @(negedge clk);
      check("R9 idle result", result, 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule